// File: doc/BRIEF.md
# DAC Latch and Update Controller

This block sits behind the serial front end of a 10-bit voltage DAC. The front end decodes bus traffic into single-cycle event pulses: a command byte, a data word, a STOP condition, and a broadcast that either requests an update or forces a clear. The block holds the staged command, the input register and the output latch. It decides when the output latch takes the input register's value, when the converter enters or leaves low-power mode, and when the reference selection changes. It drives the code to the converter core along with the power-down and reference-select lines.

Two update modes exist. In the default mode a STOP copies the input register into the output latch. In the synchronous mode a STOP leaves the latch alone, and only an update broadcast loads it. Several converters can then change together. A clear broadcast works in both modes. It zeroes both code registers and restores the command defaults. Power-down and update-mode changes wait for STOP. The reference selection moves only when the latch loads, so the code and its reference always match.

Every input is an event pulse that is accepted in the cycle it is high. There is no back-pressure, and the block has no ready output. If several pulses arrive in the same cycle, a clear wins over everything else. STOP and broadcast decisions use the register contents from before that cycle. A command byte or data word that arrives in the same cycle is stored for later use.

Top module: `dac_latch_ctrl`

## Requirements
- R1: While reset is low, and after it is released, `dac_code` is 0, `pwr_down` is 0 and `ref_internal` is 0. The block starts in STOP-update mode.
- R2: A command byte is decoded as bit 0 = synchronous-update mode, bit 1 = power-down request, bit 2 = internal-reference request. Bits 7..3 have no effect.
- R3: A data word loads only the input register. `dac_code` is unchanged until a latch load takes place.
- R4: On STOP, if the latest command has bit 0 = 0, `dac_code` takes the input register value in the next cycle.
- R5: On STOP, if the latest command has bit 0 = 1, `dac_code` is unchanged. A later update broadcast loads the latch.
- R6: An update broadcast has no effect on `dac_code` or `ref_internal` unless synchronous mode was committed by an earlier STOP.
- R7: A clear broadcast sets `dac_code`, `pwr_down` and `ref_internal` to 0, empties the input register and restores the R1 command defaults, whatever the mode.
- R8: `pwr_down` follows bit 1 of the latest command, and changes only at STOP (or at clear). The latch contents are kept while powered down.
- R9: `ref_internal` takes bit 2 of the latest command, and only when the output latch loads.
- R10: Command bits sent before a STOP govern that same STOP, including whether it loads the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte pulse |
| cmd_byte | input | 8 | Command byte value |
| word_valid | input | 1 | Data word pulse |
| word_data | input | 10 | Data word value |
| stop_pulse | input | 1 | STOP condition seen |
| bcast_pulse | input | 1 | Broadcast command seen |
| bcast_update | input | 1 | 1 = update broadcast, 0 = clear broadcast |
| dac_code | output | 10 | Output latch code to the converter |
| pwr_down | output | 1 | Low-power enable |
| ref_internal | output | 1 | 1 = internal reference, 0 = supply reference |

## Verification
STOP-only sequences with different codes and command bytes show that STOP updates in the default mode. They also show that the upper command bits are ignored and that the reference moves with the code. A sequence that first sets synchronous mode and then sends STOP separates "STOP holds" from "broadcast loads". An update broadcast sent in the default mode confirms that it is ignored. Power-down is entered and left across STOPs while codes are still loaded. Clear broadcasts in both modes, each followed by a plain STOP transaction, show that the zeroed registers and the restored default mode take effect.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int CMD_W  = 8;
  localparam int SY_POS = 0;
  localparam int SD_POS = 1;
  localparam int BG_POS = 2;

  typedef struct packed {
    logic bg;
    logic sd;
    logic sy;
  } cmd_t;

  localparam cmd_t CMD_DEFAULT = '{bg: 1'b0, sd: 1'b0, sy: 1'b0};

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_t c;
    c.sy = b[SY_POS];
    c.sd = b[SD_POS];
    c.bg = b[BG_POS];
    return c;
  endfunction
endpackage

// File: rtl/dlc_cmd_reg.sv
module dlc_cmd_reg
  import dlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             stop_pulse,
  output cmd_t             pend,
  output logic             sy_live,
  output logic             pwr_down
);
  // pend: latest command byte; sy_live / pwr_down: values committed at STOP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= CMD_DEFAULT;
      sy_live  <= 1'b0;
      pwr_down <= 1'b0;
    end else if (clear) begin
      pend     <= CMD_DEFAULT;
      sy_live  <= 1'b0;
      pwr_down <= 1'b0;
    end else begin
      if (stop_pulse) begin
        sy_live  <= pend.sy;
        pwr_down <= pend.sd;
      end
      if (cmd_valid) pend <= decode_cmd(cmd_byte);
    end
  end
endmodule

// File: rtl/dlc_latch.sv
module dlc_latch #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_valid,
  input  logic [CODE_W-1:0] word_data,
  input  logic              load,
  input  logic              load_bg,
  output logic [CODE_W-1:0] in_reg,
  output logic [CODE_W-1:0] dac_code,
  output logic              ref_internal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg       <= '0;
      dac_code     <= '0;
      ref_internal <= 1'b0;
    end else if (clear) begin
      in_reg       <= '0;
      dac_code     <= '0;
      ref_internal <= 1'b0;
    end else begin
      if (load) begin
        dac_code     <= in_reg;
        ref_internal <= load_bg;
      end
      if (word_valid) in_reg <= word_data;
    end
  end
endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
  import dlc_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              word_valid,
  input  logic [CODE_W-1:0] word_data,
  input  logic              stop_pulse,
  input  logic              bcast_pulse,
  input  logic              bcast_update,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ref_internal
);
  cmd_t              pend;
  logic              sy_live;
  logic [CODE_W-1:0] in_reg;
  logic              clear;
  logic              stop_load;
  logic              sync_load;
  logic              load;

  assign clear     = bcast_pulse & ~bcast_update;
  assign stop_load = stop_pulse & ~pend.sy;
  assign sync_load = bcast_pulse & bcast_update & sy_live;
  assign load      = stop_load | sync_load;

  dlc_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .stop_pulse (stop_pulse),
    .pend       (pend),
    .sy_live    (sy_live),
    .pwr_down   (pwr_down)
  );

  dlc_latch #(.CODE_W(CODE_W)) u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .load         (load),
    .load_bg      (pend.bg),
    .in_reg       (in_reg),
    .dac_code     (dac_code),
    .ref_internal (ref_internal)
  );
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic              stop_pulse,
  input logic              bcast_pulse,
  input logic              bcast_update,
  input logic              pend_sy,
  input logic              sy_live,
  input logic [CODE_W-1:0] in_reg,
  input logic [CODE_W-1:0] dac_code,
  input logic              pwr_down,
  input logic              ref_internal
);
  assert_reset_R1: assert property (@(posedge clk)
    (!rst_n && !stop_pulse && !bcast_pulse) |=>
      (dac_code == '0 && !pwr_down && !ref_internal));

  assert_word_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !stop_pulse && !bcast_pulse) |=> $stable(dac_code));

  assert_stop_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !bcast_pulse && !pend_sy) |=> (dac_code == $past(in_reg)));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !bcast_pulse && pend_sy) |=> $stable(dac_code));

  assert_sync_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_pulse && bcast_update && !sy_live && !stop_pulse) |=>
      ($stable(dac_code) && $stable(ref_internal)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_pulse && !bcast_update) |=>
      (dac_code == '0 && !pwr_down && !ref_internal));

  assert_pd_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_pulse && !bcast_pulse) |=> $stable(pwr_down));

  assert_ref_with_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_pulse && !bcast_pulse) |=> $stable(ref_internal));
endmodule

bind dac_latch_ctrl dlc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_valid   (word_valid),
  .stop_pulse   (stop_pulse),
  .bcast_pulse  (bcast_pulse),
  .bcast_update (bcast_update),
  .pend_sy      (pend.sy),
  .sy_live      (sy_live),
  .in_reg       (in_reg),
  .dac_code     (dac_code),
  .pwr_down     (pwr_down),
  .ref_internal (ref_internal)
);

// File: tb/sim_dac_latch_ctrl.sv
`timescale 1ns/1ps
module sim_dac_latch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       word_valid = 1'b0;
  logic [9:0] word_data = '0;
  logic       stop_pulse = 1'b0;
  logic       bcast_pulse = 1'b0;
  logic       bcast_update = 1'b0;
  logic [9:0] dac_code;
  logic       pwr_down;
  logic       ref_internal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [9:0] code;
    logic       pd;
    logic       rf;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dac_latch_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .word_valid(word_valid), .word_data(word_data),
    .stop_pulse(stop_pulse), .bcast_pulse(bcast_pulse), .bcast_update(bcast_update),
    .dac_code(dac_code), .pwr_down(pwr_down), .ref_internal(ref_internal)
  );

  // monitor: compares scoreboard entries against the outputs at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (dac_code !== e.code || pwr_down !== e.pd || ref_internal !== e.rf) begin
        errors++;
        $display("FAIL %s: code=%h pd=%b ref=%b expected code=%h pd=%b ref=%b",
                 e.tag, dac_code, pwr_down, ref_internal, e.code, e.pd, e.rf);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [9:0] c, input logic p, input logic r);
    exp_t e;
    e.tag = tag; e.code = c; e.pd = p; e.rf = r;
    sb.push_back(e);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(posedge clk); #1; cmd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [9:0] w);
    @(negedge clk); word_valid = 1'b1; word_data = w;
    @(posedge clk); #1; word_valid = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_pulse = 1'b1;
    @(posedge clk); #1; stop_pulse = 1'b0;
  endtask

  task automatic send_bcast(input logic upd);
    @(negedge clk); bcast_pulse = 1'b1; bcast_update = upd;
    @(posedge clk); #1; bcast_pulse = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 during reset", 10'h000, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1 after reset", 10'h000, 1'b0, 1'b0);

    // default mode: word is staged, STOP loads it
    send_cmd(8'h00);
    send_word(10'h155);
    expect_out("R3 word staged only", 10'h000, 1'b0, 1'b0);
    send_stop();
    expect_out("R4 stop loads", 10'h155, 1'b0, 1'b0);

    // upper bits set, BG set: bits 7..3 ignored, reference moves with load
    send_cmd(8'hFC);
    send_word(10'h3FF);
    expect_out("R9 ref waits for load", 10'h155, 1'b0, 1'b0);
    send_stop();
    expect_out("R2 R9 decode and ref with load", 10'h3FF, 1'b0, 1'b1);

    // update broadcast ignored in default mode
    send_word(10'h0AA);
    send_bcast(1'b1);
    expect_out("R6 update ignored", 10'h3FF, 1'b0, 1'b1);
    send_stop();
    expect_out("R4 second stop load", 10'h0AA, 1'b0, 1'b1);

    // synchronous mode: STOP holds, broadcast loads
    send_cmd(8'h01);
    send_word(10'h123);
    send_stop();
    expect_out("R5 R10 stop holds in sync mode", 10'h0AA, 1'b0, 1'b1);
    send_bcast(1'b1);
    expect_out("R5 R9 broadcast loads", 10'h123, 1'b0, 1'b0);

    // power-down deferred to STOP, latch kept
    send_cmd(8'h03);
    expect_out("R8 no pd before stop", 10'h123, 1'b0, 1'b0);
    send_stop();
    expect_out("R8 pd at stop", 10'h123, 1'b1, 1'b0);
    send_word(10'h2F0);
    send_bcast(1'b1);
    expect_out("R8 load while powered down", 10'h2F0, 1'b1, 1'b0);

    // leaving sync mode: this STOP uses its own command
    send_cmd(8'h00);
    send_word(10'h1C1);
    send_stop();
    expect_out("R10 R8 own stop loads and wakes", 10'h1C1, 1'b0, 1'b0);

    // clear while in sync mode
    send_cmd(8'h07);
    send_word(10'h3AB);
    send_stop();
    expect_out("R8 R5 sync pd commit", 10'h1C1, 1'b1, 1'b0);
    send_bcast(1'b0);
    expect_out("R7 clear in sync mode", 10'h000, 1'b0, 1'b0);
    send_stop();
    expect_out("R7 input register emptied", 10'h000, 1'b0, 1'b0);
    send_word(10'h077);
    send_stop();
    expect_out("R7 defaults restored", 10'h077, 1'b0, 1'b0);

    // clear in default mode
    send_cmd(8'h04);
    send_word(10'h311);
    send_stop();
    expect_out("R9 internal ref", 10'h311, 1'b0, 1'b1);
    send_bcast(1'b0);
    expect_out("R7 clear in default mode", 10'h000, 1'b0, 1'b0);

    // power-down enter and exit in default mode
    send_cmd(8'h02);
    send_word(10'h0F0);
    send_stop();
    expect_out("R8 pd enter default mode", 10'h0F0, 1'b1, 1'b0);
    send_cmd(8'hF8);
    send_stop();
    expect_out("R2 R8 pd exit, upper bits ignored", 10'h0F0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule